// File: doc/BRIEF.md
# Block Cipher Chaining and Key Writeback Controller

This controller sits in front of a 128-bit block cipher core and runs a stream of blocks through it, one at a time, over a start/done handshake. Each operation is set up by a context load that programs the chaining mode (independent blocks or cipher block chaining), the direction (encrypt or decrypt), a 128-bit key held as four 32-bit words, a 128-bit initial chaining value, and a key-writeback enable. Blocks then arrive on a valid/ready stream. Each result leaves on a one-cycle output strobe.

In chained mode the controller combines each block with the chaining register and updates that register after every block. Software can therefore read the running value back or resume from it. With key writeback enabled, the first result produced after a context load replaces the key. This lets a key be encrypted under itself. A later decrypt with writeback, run under the original key, restores that key into the key register. The cipher rounds live outside this block. The core is reached through its own start, direction, key, data and done pins.

Top module: `blk_chain_ctrl`

## Requirements
- R1: After reset, in_ready is 1, out_valid and core_start are 0, and st_iv and st_key read all zeros.
- R2: A cfg_load pulse while no block is in flight copies cfg_key, cfg_iv and the three mode bits into the context, visible on st_key and st_iv the next cycle, and in_ready is 0 in the load cycle. A cfg_load pulse while a block is in flight is ignored, and st_key and st_iv then keep their values.
- R3: Only one block is in flight. in_ready is 0 from the cycle after acceptance up to and including the cycle of out_valid, and it returns to 1 the cycle after.
- R4: core_start pulses for exactly one cycle, one cycle after a block is accepted. In that cycle core_key equals st_key and core_decrypt equals the loaded direction bit.
- R5: In independent-block mode (cfg_cbc=0), core_din is the input block, out_data is core_dout, and st_iv never changes.
- R6: In chained encrypt (cfg_cbc=1, cfg_decrypt=0), core_din is the input block XOR st_iv, out_data is core_dout, and st_iv becomes that output.
- R7: In chained decrypt (cfg_cbc=1, cfg_decrypt=1), core_din is the input block, out_data is core_dout XOR st_iv, and st_iv becomes that input block. Decrypting a chained-encrypt stream with the same key and initial value returns the plaintext.
- R8: out_valid is high for exactly the one cycle in which core_done is high while a block is in flight. A core_done while idle produces no output and changes no state.
- R9: With cfg_key_wb=1, the first out_data after the context load is written into the key register, so that st_key equals it the next cycle. Key word i is bits [32i+31:32i].
- R10: After that writeback, later blocks of the same context use the new key and never write the key again.
- R11: Encrypting key K under K with writeback and then decrypting the result under K with writeback leaves K in st_key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Context load strobe |
| cfg_cbc | input | 1 | 1 = chained mode, 0 = independent blocks |
| cfg_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| cfg_key_wb | input | 1 | Arm key writeback for this context |
| cfg_key | input | 128 | Key, word i in bits [32i+31:32i] |
| cfg_iv | input | 128 | Initial chaining value |
| in_valid | input | 1 | Input block valid |
| in_data | input | 128 | Input block |
| in_ready | output | 1 | Block can be accepted |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 128 | Result block |
| core_start | output | 1 | Start pulse to cipher core |
| core_decrypt | output | 1 | Direction to cipher core |
| core_key | output | 128 | Key to cipher core |
| core_din | output | 128 | Data to cipher core |
| core_done | input | 1 | Cipher core completion |
| core_dout | input | 128 | Cipher core result |
| st_iv | output | 128 | Current chaining register |
| st_key | output | 128 | Current key register |

## Verification
A chaining register that picks up the wrong value shows on the very next chained block. There it corrupts core_din in encrypt, or out_data in decrypt, and it is visible on st_iv one cycle after the done strobe. A writeback flag left armed, or dropped too early, shows as an st_key mismatch one cycle after the first or second result. The key then reaches core_key on the next start pulse. A stale busy state shows at once as in_ready or out_valid disagreeing with the handshake count in the cycle-by-cycle model.

// File: rtl/blk_chain_pkg.sv
package blk_chain_pkg;
  parameter int BLK_W  = 128;
  parameter int WORD_W = 32;

  typedef struct packed {
    logic cbc;
    logic dec;
    logic key_wb;
  } ctx_mode_t;
endpackage

// File: rtl/blk_chain_seq.sv
module blk_chain_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic in_valid,
  input  logic core_done,
  output logic in_ready,
  output logic accept,
  output logic load_ok,
  output logic fin,
  output logic busy,
  output logic start
);
  logic busy_q, busy_nxt;
  logic start_q, start_nxt;

  always_comb begin
    in_ready  = !busy_q && !cfg_load;
    accept    = in_valid && in_ready;
    load_ok   = cfg_load && !busy_q;
    fin       = core_done && busy_q;
    busy_nxt  = busy_q;
    if (accept)   busy_nxt = 1'b1;
    else if (fin) busy_nxt = 1'b0;
    start_nxt = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      busy_q  <= busy_nxt;
      start_q <= start_nxt;
    end
  end

  assign busy  = busy_q;
  assign start = start_q;

  p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_fin_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy_q);
endmodule

// File: rtl/blk_chain_reg.sv
module blk_chain_reg #(
  parameter int BLK_W = blk_chain_pkg::BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_iv,
  input  logic             cbc,
  input  logic             dec,
  input  logic             accept,
  input  logic [BLK_W-1:0] in_data,
  input  logic             fin,
  input  logic [BLK_W-1:0] core_dout,
  output logic [BLK_W-1:0] core_din,
  output logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] chain
);
  logic [BLK_W-1:0] chain_q, chain_nxt;
  logic [BLK_W-1:0] din_q, din_nxt;
  logic [BLK_W-1:0] held_q, held_nxt;
  logic             chain_en;

  always_comb begin
    din_nxt  = (cbc && !dec) ? (in_data ^ chain_q) : in_data;
    held_nxt = in_data;
    result   = (cbc && dec) ? (core_dout ^ chain_q) : core_dout;
    chain_en = load || (fin && cbc);
    if (load)     chain_nxt = load_iv;
    else if (dec) chain_nxt = held_q;
    else          chain_nxt = core_dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else if (chain_en) chain_q <= chain_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= '0;
      held_q <= '0;
    end else if (accept) begin
      din_q  <= din_nxt;
      held_q <= held_nxt;
    end
  end

  assign core_din = din_q;
  assign chain    = chain_q;

  p_ecb_chain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cbc) |=> $stable(chain_q));
  p_chain_only_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !fin) |=> $stable(chain_q));
endmodule

// File: rtl/blk_key_store.sv
module blk_key_store #(
  parameter int BLK_W  = blk_chain_pkg::BLK_W,
  parameter int WORD_W = blk_chain_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_key,
  input  logic             load_wb,
  input  logic             fin,
  input  logic             busy,
  input  logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] key
);
  localparam int NWORDS = BLK_W / WORD_W;

  logic armed_q, armed_nxt;
  logic wb_hit;

  always_comb begin
    wb_hit    = fin && armed_q;
    armed_nxt = armed_q;
    if (load)     armed_nxt = load_wb;
    else if (fin) armed_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_nxt;
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q, w_nxt;
    logic              w_en;
    always_comb begin
      w_en  = load || wb_hit;
      w_nxt = load ? load_key[g*WORD_W +: WORD_W] : result[g*WORD_W +: WORD_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= w_nxt;
    end
    assign key[g*WORD_W +: WORD_W] = w_q;
  end

  p_wb_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !load) |=> !armed_q);
  p_key_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(key));
endmodule

// File: rtl/blk_chain_ctrl.sv
module blk_chain_ctrl #(
  parameter int BLK_W  = blk_chain_pkg::BLK_W,
  parameter int WORD_W = blk_chain_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_cbc,
  input  logic             cfg_decrypt,
  input  logic             cfg_key_wb,
  input  logic [BLK_W-1:0] cfg_key,
  input  logic [BLK_W-1:0] cfg_iv,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_data,
  output logic             core_start,
  output logic             core_decrypt,
  output logic [BLK_W-1:0] core_key,
  output logic [BLK_W-1:0] core_din,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_dout,
  output logic [BLK_W-1:0] st_iv,
  output logic [BLK_W-1:0] st_key
);
  import blk_chain_pkg::*;

  ctx_mode_t        mode_q, mode_nxt;
  logic             accept, load_ok, fin, busy;
  logic [BLK_W-1:0] result;

  blk_chain_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .in_valid(in_valid),
    .core_done(core_done), .in_ready(in_ready), .accept(accept),
    .load_ok(load_ok), .fin(fin), .busy(busy), .start(core_start)
  );

  always_comb begin
    mode_nxt = mode_q;
    if (load_ok) mode_nxt = '{cbc: cfg_cbc, dec: cfg_decrypt, key_wb: cfg_key_wb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_nxt;
  end

  blk_chain_reg #(.BLK_W(BLK_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_iv(cfg_iv),
    .cbc(mode_q.cbc), .dec(mode_q.dec), .accept(accept), .in_data(in_data),
    .fin(fin), .core_dout(core_dout), .core_din(core_din),
    .result(result), .chain(st_iv)
  );

  blk_key_store #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_key (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_key(cfg_key),
    .load_wb(cfg_key_wb), .fin(fin), .busy(busy), .result(result),
    .key(st_key)
  );

  assign core_key     = st_key;
  assign core_decrypt = mode_q.dec;
  assign out_valid    = fin;
  assign out_data     = result;

  p_accept_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> core_start);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_no_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !in_ready);
endmodule

// File: tb/test_blk_chain_ctrl.sv
module test_blk_chain_ctrl;
  localparam int W = 128;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_cbc = 1'b0, cfg_decrypt = 1'b0, cfg_key_wb = 1'b0;
  logic [W-1:0] cfg_key = '0, cfg_iv = '0, in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid, core_start, core_decrypt;
  logic [W-1:0] out_data, core_key, core_din, st_iv, st_key;
  logic core_done_r = 1'b0, spur = 1'b0;
  logic core_done;
  logic [W-1:0] core_dout = '0;
  int ccnt = 0;

  int total = 0, fails = 0;

  // model state
  logic [W-1:0] mkey = '0, miv = '0;
  bit mcbc = 0, mdec = 0, mwb = 0;

  always #5 clk = ~clk;

  function automatic logic [W-1:0] encf(logic [W-1:0] x, logic [W-1:0] k);
    logic [W-1:0] t;
    t = x ^ k;
    return {t[W-14:0], t[W-1:W-13]};
  endfunction

  function automatic logic [W-1:0] decf(logic [W-1:0] y, logic [W-1:0] k);
    return {y[12:0], y[W-1:13]} ^ k;
  endfunction

  // stand-in cipher core
  always @(posedge clk) begin
    if (core_start) begin
      ccnt        <= LAT;
      core_done_r <= 1'b0;
      core_dout   <= core_decrypt ? decf(core_din, core_key) : encf(core_din, core_key);
    end else if (ccnt > 0) begin
      ccnt        <= ccnt - 1;
      core_done_r <= (ccnt == 1);
    end else begin
      core_done_r <= 1'b0;
    end
  end
  assign core_done = core_done_r | spur;

  blk_chain_ctrl i_blk_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cbc(cfg_cbc),
    .cfg_decrypt(cfg_decrypt), .cfg_key_wb(cfg_key_wb), .cfg_key(cfg_key),
    .cfg_iv(cfg_iv), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .core_start(core_start),
    .core_decrypt(core_decrypt), .core_key(core_key), .core_din(core_din),
    .core_done(core_done), .core_dout(core_dout), .st_iv(st_iv), .st_key(st_key)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic load_ctx(input logic [W-1:0] k, input logic [W-1:0] iv,
                          input bit cbc, input bit dec, input bit wb);
    @(negedge clk);
    cfg_key = k; cfg_iv = iv; cfg_cbc = cbc; cfg_decrypt = dec; cfg_key_wb = wb;
    cfg_load = 1'b1;
    #1 chk(in_ready == 1'b0, "R2 ready low in load cycle", W'(in_ready), W'(0));
    @(negedge clk);
    cfg_load = 1'b0;
    mkey = k; miv = iv; mcbc = cbc; mdec = dec; mwb = wb;
    chk(st_key == mkey, "R2 key loaded", st_key, mkey);
    chk(st_iv == miv, "R2 iv loaded", st_iv, miv);
  endtask

  task automatic run_block(input logic [W-1:0] blk, input bit poke, output logic [W-1:0] res);
    logic [W-1:0] cin, cout;
    int waited;
    cin  = (mcbc && !mdec) ? (blk ^ miv) : blk;
    cout = mdec ? decf(cin, mkey) : encf(cin, mkey);
    res  = (mcbc && mdec) ? (cout ^ miv) : cout;
    @(negedge clk);
    in_valid = 1'b1; in_data = blk;
    @(negedge clk);
    in_valid = 1'b0;
    chk(core_start == 1'b1, "R4 start pulse", W'(core_start), W'(1));
    chk(core_key == mkey, "R4 core key", core_key, mkey);
    chk(core_decrypt == mdec, "R4 core direction", W'(core_decrypt), W'(mdec));
    chk(core_din == cin, mcbc ? (mdec ? "R7 core_din" : "R6 core_din") : "R5 core_din", core_din, cin);
    waited = 0;
    @(negedge clk);
    chk(core_start == 1'b0, "R4 start one cycle", W'(core_start), W'(0));
    while (!out_valid && waited < 20) begin
      chk(in_ready == 1'b0, "R3 ready low in flight", W'(in_ready), W'(0));
      if (poke && waited == 0) begin
        cfg_load = 1'b1; cfg_key = ~mkey; cfg_iv = ~miv;
      end else begin
        cfg_load = 1'b0;
      end
      waited++;
      @(negedge clk);
    end
    cfg_load = 1'b0;
    chk(out_valid == 1'b1, "R8 done strobe", W'(out_valid), W'(1));
    chk(out_data == res, mcbc ? (mdec ? "R7 result" : "R6 result") : "R5 result", out_data, res);
    chk(in_ready == 1'b0, "R3 ready low in done cycle", W'(in_ready), W'(0));
    if (mcbc) miv = mdec ? blk : cout;
    if (mwb) begin mkey = res; mwb = 0; end
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 strobe one cycle", W'(out_valid), W'(0));
    chk(in_ready == 1'b1, "R3 ready back", W'(in_ready), W'(1));
    chk(st_iv == miv, mcbc ? "R6 R7 chain update" : "R5 chain unchanged", st_iv, miv);
    chk(st_key == mkey, "R9 R10 key register", st_key, mkey);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired act=%h exp=%h", W'(0), W'(1));
    summary();
  end

  initial begin
    logic [W-1:0] k1, k2, v1, r, ek;
    logic [W-1:0] pt[3];
    logic [W-1:0] ct[3];
    k1 = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    k2 = 128'h13579bdf_2468ace0_fedcba98_76543210;
    v1 = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    pt[0] = 128'h11111111_22222222_33333333_44444444;
    pt[1] = 128'h11111111_22222222_33333333_44444444;
    pt[2] = 128'h0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready", W'(in_ready), W'(1));
    chk(out_valid == 1'b0, "R1 out_valid", W'(out_valid), W'(0));
    chk(core_start == 1'b0, "R1 core_start", W'(core_start), W'(0));
    chk(st_iv == '0, "R1 iv", st_iv, '0);
    chk(st_key == '0, "R1 key", st_key, '0);

    // R5 independent blocks
    load_ctx(k1, v1, 0, 0, 0);
    run_block(pt[0], 0, r);
    run_block(pt[1], 0, r);

    // R6 chained encrypt
    load_ctx(k1, v1, 1, 0, 0);
    for (int i = 0; i < 3; i++) run_block(pt[i], 0, ct[i]);
    chk(ct[0] != ct[1], "R6 equal plaintexts differ", ct[0], ct[1]);

    // R7 chained decrypt returns plaintext; R2 busy load ignored
    load_ctx(k1, v1, 1, 1, 0);
    for (int i = 0; i < 3; i++) begin
      run_block(ct[i], (i == 1), r);
      chk(r == pt[i], "R7 round trip", r, pt[i]);
    end
    chk(st_key == k1, "R2 busy load ignored key", st_key, k1);

    // R8 spurious done while idle
    @(negedge clk);
    spur = 1'b1;
    #1 chk(out_valid == 1'b0, "R8 idle done no output", W'(out_valid), W'(0));
    @(negedge clk);
    spur = 1'b0;
    chk(st_iv == miv, "R8 idle done iv unchanged", st_iv, miv);
    chk(st_key == mkey, "R8 idle done key unchanged", st_key, mkey);
    chk(in_ready == 1'b1, "R8 idle done ready", W'(in_ready), W'(1));

    // R9 R10 key writeback, encrypt key under itself
    load_ctx(k2, v1, 0, 0, 1);
    run_block(k2, 0, ek);
    chk(st_key == ek, "R9 key written back", st_key, ek);
    run_block(pt[0], 0, r);
    chk(st_key == ek, "R10 no second writeback", st_key, ek);

    // R11 restore
    load_ctx(k2, v1, 0, 1, 1);
    run_block(ek, 0, r);
    chk(st_key == k2, "R11 key restored", st_key, k2);

    summary();
  end
endmodule